// File: doc/BRIEF.md
# Extended-State Save Selection Sequencer

This block plans an optimized save of processor extended state. After a start pulse it captures the instruction mask, the enable register, the in-use and modified bitmaps, the header bitvector already held in the save area, a stored tracking tuple, and the current privilege level, non-root flag and save-area linear address. From these it works out which state components have to be written. It then issues one store request per selected item over a valid/ready channel. The last request carries the merged header bitvector. A single-cycle done pulse follows the acceptance of that last request.

A store request carries an item kind, a component index and an offset. The offset for extended components comes from a combinational lookup port that is indexed by component number. The block moves no register data and has no connection to the memory bus. The datapath that carries out each request reads the kind and index to find out what to copy.

Top module: `state_save_seq`

## Requirements
- R1: The requested set is the bitwise AND of the instruction mask and the enable register. A component whose requested bit is clear is never stored, even when it is in use.
- R2: When the tracking tuple does not match, the save set is the requested set ANDed with the in-use bitmap.
- R3: The tracking tuple matches only when it equals the concatenation, MSB first, of {privilege level (2 bits), non-root flag (1 bit), save-area address (64 bits), 64 zero bits}. On a match the save set is further ANDed with the modified bitmap.
- R4: Requests come out in a fixed order. First is x87 (kind 0, index 0) if save-set bit 0 is set. Next is the vector registers (kind 1, index 1) if save-set bit 1 is set. Next is the control/status word with its mask (kind 2, index 1). Last come the extended components (kind 3), with indices 2 to 62 in ascending order for each set save-set bit. Component 63 is never stored.
- R5: The control/status word request is issued whenever requested bit 1 or requested bit 2 is set, whatever the in-use and modified bitmaps hold.
- R6: An extended request carries the lookup offset for its own index, and the lookup index output equals the request index. Requests of kinds 0, 1 and 2 carry offset 0.
- R7: The last request has kind 4 and carries the new header (old AND NOT requested) OR (in-use AND requested).
- R8: While valid is high and ready is low, the request stays unchanged.
- R9: With ready held high, a new request is accepted every cycle, and clear save-set bits cost no cycles. done pulses high for exactly one cycle, in the cycle after the header request is accepted.
- R10: A start pulse that arrives while busy is high is ignored and does not change the sequence in progress.
- R11: After reset, busy, valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a save plan; all inputs are captured this cycle |
| instr_mask | input | 64 | Instruction component mask |
| enable_reg | input | 64 | Enabled-components register |
| inuse_map | input | 64 | Components currently in use |
| modified_map | input | 64 | Components modified since the last restore |
| old_header | input | 64 | Header bitvector currently in the save area |
| track_tuple | input | 131 | Stored tracking tuple |
| cur_priv | input | 2 | Current privilege level |
| non_root | input | 1 | 1 when running in virtualization non-root operation |
| area_addr | input | 64 | Linear address of the save area |
| lut_index | output | 6 | Component index presented to the offset lookup |
| lut_offset | input | 32 | Offset returned by the lookup |
| req_valid | output | 1 | Store request valid |
| req_kind | output | 3 | 0 x87, 1 vector, 2 control/status, 3 extended, 4 header |
| req_index | output | 6 | Component index of the request |
| req_offset | output | 32 | Offset for extended requests, else 0 |
| req_header | output | 64 | New header bitvector (used with kind 4) |
| req_ready | input | 1 | Memory side accepts the request |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The main function is driven through a table of mask, enable, in-use, modified and header patterns. Pairs of rows differ only in whether the tracking tuple matches. These pairs show that pruning by the modified bitmap applies on a match and is skipped otherwise. The tuple is broken in three separate ways: by the address, by the privilege level, and by a non-zero low field. Other rows check one case each: the control/status rule with in-use cleared, a requested set with only bit 2, an empty request with only the header, and a sparse set ending at component 62 with bit 63 set in every map. Every row is run once with ready held high, to measure cycle counts, and once with ready stalling, to check that requests hold. A directed run fires a second start in the middle of a sequence.

// File: rtl/state_save_pkg.sv
package state_save_pkg;

   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      KIND_X87 = 3'd0,
      KIND_VEC = 3'd1,
      KIND_CSR = 3'd2,
      KIND_EXT = 3'd3,
      KIND_HDR = 3'd4
   } req_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HDR  = 2'd2
   } seq_state_e;

   // Work-vector slot positions: 0 x87, 1 vector, 2 control/status,
   // slot p >= 3 holds extended component p-1.
   localparam int SLOT_X87 = 0;
   localparam int SLOT_VEC = 1;
   localparam int SLOT_CSR = 2;
   localparam int SLOT_EXT = 3;

endpackage

// File: rtl/ss_select_calc.sv
module ss_select_calc #(
   parameter int NCOMP  = 64,
   parameter int PL_W   = 2,
   parameter int ADDR_W = 64,
   parameter int ZERO_W = 64,
   localparam int TUPLE_W = PL_W + 1 + ADDR_W + ZERO_W
) (
   input  logic [NCOMP-1:0]   instr_mask,
   input  logic [NCOMP-1:0]   enable_reg,
   input  logic [NCOMP-1:0]   inuse_map,
   input  logic [NCOMP-1:0]   modified_map,
   input  logic [NCOMP-1:0]   old_header,
   input  logic [TUPLE_W-1:0] track_tuple,
   input  logic [PL_W-1:0]    cur_priv,
   input  logic               non_root,
   input  logic [ADDR_W-1:0]  area_addr,
   output logic [NCOMP-1:0]   work_vec,
   output logic [NCOMP-1:0]   new_header
);
   import state_save_pkg::*;

   localparam int LAST_EXT = NCOMP - 2;

   logic [NCOMP-1:0]   req_set;
   logic [TUPLE_W-1:0] live_tuple;
   logic               tuple_hit;
   logic [LAST_EXT:0]  save_set;
   logic               unused_top_modified;

   // R1 requested set
   assign req_set    = instr_mask & enable_reg;
   // R3 exact tuple compare including the zero field
   assign live_tuple = {cur_priv, non_root, area_addr, {ZERO_W{1'b0}}};
   assign tuple_hit  = (track_tuple == live_tuple);

   // R2/R3 save set, top component never stored
   assign save_set = req_set[LAST_EXT:0] & inuse_map[LAST_EXT:0]
                   & (tuple_hit ? modified_map[LAST_EXT:0] : {(LAST_EXT+1){1'b1}});
   assign unused_top_modified = modified_map[NCOMP-1];

   // Work vector in issue order (R4, R5)
   assign work_vec[SLOT_X87] = save_set[0];
   assign work_vec[SLOT_VEC] = save_set[1];
   assign work_vec[SLOT_CSR] = req_set[1] | req_set[2];
   generate
      for (genvar p = SLOT_EXT; p < NCOMP; p++) begin : g_ext_slot
         assign work_vec[p] = save_set[p-1];
      end
   endgenerate

   // R7 header merge
   assign new_header = (old_header & ~req_set) | (inuse_map & req_set);

endmodule

// File: rtl/ss_lowest_pick.sv
module ss_lowest_pick #(
   parameter int W          = 64,
   parameter int FIND_STYLE = 0,
   localparam int PW        = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [W-1:0]  onehot,
   output logic [PW-1:0] pos,
   output logic          any
);
   assign any = |vec;

   generate
      if (FIND_STYLE == 0) begin : g_scan
         // Descending scan: the last hit written is the lowest set bit
         always_comb begin
            pos = '0;
            for (int i = W - 1; i >= 0; i--) begin
               if (vec[i]) pos = PW'(i);
            end
         end
         assign onehot = any ? (W'(1) << pos) : '0;
      end else if (FIND_STYLE == 1) begin : g_isolate
         // Two's-complement isolate, then encode the one-hot word
         assign onehot = vec & (~vec + W'(1));
         always_comb begin
            pos = '0;
            for (int b = 0; b < PW; b++) begin
               for (int i = 0; i < W; i++) begin
                  if ((((i >> b) & 1) != 0) && onehot[i]) pos[b] = 1'b1;
               end
            end
         end
      end else begin : g_bad_style
         $error("ss_lowest_pick: FIND_STYLE must be 0 or 1");
      end
   endgenerate

   always_comb begin
      assert_pick_onehot_R9: assert ($onehot0(onehot))
         else $error("pick output not one-hot");
   end

endmodule

// File: rtl/state_save_seq.sv
module state_save_seq #(
   parameter int NCOMP      = 64,
   parameter int PL_W       = 2,
   parameter int ADDR_W     = 64,
   parameter int ZERO_W     = 64,
   parameter int OFF_W      = 32,
   parameter int FIND_STYLE = 0,
   localparam int IDX_W     = $clog2(NCOMP),
   localparam int TUPLE_W   = PL_W + 1 + ADDR_W + ZERO_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [NCOMP-1:0]   instr_mask,
   input  logic [NCOMP-1:0]   enable_reg,
   input  logic [NCOMP-1:0]   inuse_map,
   input  logic [NCOMP-1:0]   modified_map,
   input  logic [NCOMP-1:0]   old_header,
   input  logic [TUPLE_W-1:0] track_tuple,
   input  logic [PL_W-1:0]    cur_priv,
   input  logic               non_root,
   input  logic [ADDR_W-1:0]  area_addr,
   output logic [IDX_W-1:0]   lut_index,
   input  logic [OFF_W-1:0]   lut_offset,
   output logic               req_valid,
   output logic [2:0]         req_kind,
   output logic [IDX_W-1:0]   req_index,
   output logic [OFF_W-1:0]   req_offset,
   output logic [NCOMP-1:0]   req_header,
   input  logic               req_ready,
   output logic               busy,
   output logic               done
);
   import state_save_pkg::*;

   generate
      if (NCOMP < 4) begin : g_bad_ncomp
         $error("state_save_seq: NCOMP must be at least 4");
      end
      if (NCOMP != (1 << IDX_W)) begin : g_bad_pow2
         $error("state_save_seq: NCOMP must be a power of two");
      end
      if (OFF_W < 1 || PL_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("state_save_seq: widths must be positive");
      end
   endgenerate

   seq_state_e       state_q;
   logic [NCOMP-1:0] work_q;
   logic [NCOMP-1:0] hdr_q;
   logic             done_q;

   logic [NCOMP-1:0] work_d;
   logic [NCOMP-1:0] hdr_d;
   logic [NCOMP-1:0] pick_oh;
   logic [IDX_W-1:0] pick_pos;
   logic             pick_any;
   logic [NCOMP-1:0] work_left;
   req_kind_e        cur_kind;
   logic [IDX_W-1:0] cur_index;
   logic             accept;

   ss_select_calc #(
      .NCOMP (NCOMP), .PL_W (PL_W), .ADDR_W (ADDR_W), .ZERO_W (ZERO_W)
   ) u_calc (
      .instr_mask   (instr_mask),
      .enable_reg   (enable_reg),
      .inuse_map    (inuse_map),
      .modified_map (modified_map),
      .old_header   (old_header),
      .track_tuple  (track_tuple),
      .cur_priv     (cur_priv),
      .non_root     (non_root),
      .area_addr    (area_addr),
      .work_vec     (work_d),
      .new_header   (hdr_d)
   );

   ss_lowest_pick #(.W (NCOMP), .FIND_STYLE (FIND_STYLE)) u_pick (
      .vec    (work_q),
      .onehot (pick_oh),
      .pos    (pick_pos),
      .any    (pick_any)
   );

   // Slot position to request kind and component index (R4)
   always_comb begin
      if (state_q == ST_HDR) begin
         cur_kind  = KIND_HDR;
         cur_index = '0;
      end else if (pick_pos == IDX_W'(SLOT_X87)) begin
         cur_kind  = KIND_X87;
         cur_index = '0;
      end else if (pick_pos == IDX_W'(SLOT_VEC)) begin
         cur_kind  = KIND_VEC;
         cur_index = IDX_W'(1);
      end else if (pick_pos == IDX_W'(SLOT_CSR)) begin
         cur_kind  = KIND_CSR;
         cur_index = IDX_W'(1);
      end else begin
         cur_kind  = KIND_EXT;
         cur_index = pick_pos - IDX_W'(1);
      end
   end

   assign req_valid  = ((state_q == ST_RUN) && pick_any) || (state_q == ST_HDR);
   assign req_kind   = cur_kind;
   assign req_index  = cur_index;
   assign lut_index  = cur_index;
   assign req_offset = (state_q == ST_RUN && cur_kind == KIND_EXT) ? lut_offset : '0;
   assign req_header = hdr_q;
   assign accept     = req_valid && req_ready;
   assign work_left  = work_q & ~pick_oh;
   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         work_q  <= '0;
         hdr_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  work_q  <= work_d;
                  hdr_q   <= hdr_d;
                  state_q <= (work_d != '0) ? ST_RUN : ST_HDR;
               end
            end
            ST_RUN: begin
               if (accept) begin
                  work_q <= work_left;
                  if (work_left == '0) state_q <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (accept) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R8: a stalled request is held unchanged
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_kind)
         && $stable(req_index) && $stable(req_offset) && $stable(req_header)))
      else $error("stalled request changed");

   // R9: done only right after the header is accepted
   assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(req_valid && req_ready && req_kind == 3'(KIND_HDR)))
      else $error("done without header acceptance");

   // R4: extended indices ascend
   assert_ascend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_kind == 3'(KIND_EXT)) |=>
         (!req_valid || req_kind != 3'(KIND_EXT) || req_index > $past(req_index)))
      else $error("extended indices not ascending");

   // R4: extended indices stay within 2..NCOMP-2
   assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 3'(KIND_EXT)) |->
         (req_index >= IDX_W'(2) && req_index <= IDX_W'(NCOMP - 2)))
      else $error("extended index out of range");

   // R10: captured header is untouched while busy
   assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(req_header))
      else $error("header changed during a sequence");

   // R11: nothing valid when idle
   assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid)
      else $error("request valid while idle");

endmodule

// File: tb/test_state_save_seq.sv
module test_state_save_seq;

   localparam int NC = 64;
   localparam int TW = 2 + 1 + 64 + 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [63:0]   instr_mask = '0, enable_reg = '0, inuse_map = '0;
   logic [63:0]   modified_map = '0, old_header = '0;
   logic [TW-1:0] track_tuple = '0;
   logic [1:0]    cur_priv = 2'd3;
   logic          non_root = 1'b1;
   logic [63:0]   area_addr = 64'h0000_7FFF_1234_5600;
   logic [5:0]    lut_index;
   logic [31:0]   lut_offset;
   logic          req_valid;
   logic [2:0]    req_kind;
   logic [5:0]    req_index;
   logic [31:0]   req_offset;
   logic [63:0]   req_header;
   logic          req_ready = 1'b0;
   logic          busy, done;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   assign lut_offset = 32'h0000_4000 + 32'(lut_index) * 32'd64;

   state_save_seq i_state_save_seq (
      .clk (clk), .rst_n (rst_n), .start (start),
      .instr_mask (instr_mask), .enable_reg (enable_reg),
      .inuse_map (inuse_map), .modified_map (modified_map),
      .old_header (old_header), .track_tuple (track_tuple),
      .cur_priv (cur_priv), .non_root (non_root), .area_addr (area_addr),
      .lut_index (lut_index), .lut_offset (lut_offset),
      .req_valid (req_valid), .req_kind (req_kind), .req_index (req_index),
      .req_offset (req_offset), .req_header (req_header),
      .req_ready (req_ready), .busy (busy), .done (done)
   );

   typedef struct packed {
      logic [63:0] mask;
      logic [63:0] en;
      logic [63:0] inuse;
      logic [63:0] modif;
      logic [63:0] oldh;
      logic [1:0]  tsel;   // 0 match, 1 bad address, 2 bad low field, 3 bad privilege
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VT [0:NV-1] = '{
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 2'd1},
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 2'd0},
      '{64'h8000_0000_0000_0007, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0005, 64'h0, 64'hFFFF_0000_0000_00F0, 2'd1},
      '{64'h0000_0000_0000_0004, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_000C, 2'd2},
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_00F0_0000_0003, 64'h0000_0050_0000_0002, 64'h0000_0040_0000_0000, 64'h0, 2'd0},
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_00F0_0000_0003, 64'h0000_0050_0000_0002, 64'h0000_0040_0000_0000, 64'h0, 2'd3},
      '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 2'd1},
      '{64'hC000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd1}
   };

   logic [2:0]  ek [0:79];
   logic [5:0]  ei [0:79];
   int          n_exp;
   logic [63:0] exp_hdr;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic add_item(input logic [2:0] k, input logic [5:0] i);
      ek[n_exp] = k;
      ei[n_exp] = i;
      n_exp++;
   endtask

   // Reference plan computed from the requirements
   task automatic build_expected(input vec_t v);
      logic [63:0] rq, ss;
      rq = v.mask & v.en;                          // R1
      ss = rq & v.inuse;                           // R2
      if (v.tsel == 2'd0) ss = ss & v.modif;       // R3
      n_exp = 0;
      if (ss[0]) add_item(3'd0, 6'd0);             // R4
      if (ss[1]) add_item(3'd1, 6'd1);
      if (rq[1] || rq[2]) add_item(3'd2, 6'd1);    // R5
      for (int i = 2; i <= 62; i++) if (ss[i]) add_item(3'd3, 6'(i));
      exp_hdr = (v.oldh & ~rq) | (v.inuse & rq);   // R7
   endtask

   function automatic logic [TW-1:0] tuple_for(input logic [1:0] tsel);
      logic [TW-1:0] t;
      t = {cur_priv, non_root, area_addr, 64'h0};
      case (tsel)
         2'd1: t = {cur_priv, non_root, area_addr ^ 64'h40, 64'h0};
         2'd2: t = {cur_priv, non_root, area_addr, 64'h1};
         2'd3: t = {2'd0, non_root, area_addr, 64'h0};
         default: ;
      endcase
      return t;
   endfunction

   task automatic run_case(input vec_t v, input bit full_ready, input bit restart_mid);
      int  n;
      bit  seen_done;
      string ctag;
      build_expected(v);
      ctag = (v.tsel == 2'd0) ? "R3" : "R2";
      @(negedge clk);
      instr_mask = v.mask; enable_reg = v.en; inuse_map = v.inuse;
      modified_map = v.modif; old_header = v.oldh; track_tuple = tuple_for(v.tsel);
      start = 1'b1;
      n = 0;
      seen_done = 1'b0;
      for (int cyc = 1; cyc < 400 && !seen_done; cyc++) begin
         @(negedge clk);
         start = 1'b0;
         if (restart_mid && cyc == 2) begin
            start = 1'b1;                  // R10: ignored while busy
            instr_mask = 64'h0; inuse_map = 64'h0; old_header = 64'hDEAD_BEEF_0000_0000;
         end
         req_ready = full_ready ? 1'b1 : ((cyc % 3) != 0);
         if (req_valid) begin
            if (n < n_exp) begin
               chk(req_kind == ek[n] && req_index == ei[n], "R4", "kind/index",
                   {55'h0, req_kind, req_index}, {55'h0, ek[n], ei[n]});
               chk(req_offset == ((ek[n] == 3'd3) ? 32'h4000 + 32'(ei[n]) * 32'd64 : 32'h0)
                   && lut_index == ei[n], "R6", "offset",
                   {32'h0, req_offset}, {32'h0, (ek[n] == 3'd3) ? 32'h4000 + 32'(ei[n]) * 32'd64 : 32'h0});
            end else begin
               chk(n == n_exp && req_kind == 3'd4, "R7", "header kind",
                   {61'h0, req_kind}, 64'd4);
               chk(req_header == exp_hdr, "R7", "header value", req_header, exp_hdr);
            end
            if (req_ready) n++;
         end
         if (done) begin
            seen_done = 1'b1;
            chk(n == n_exp + 1, ctag, "request count", 64'(n), 64'(n_exp + 1));
            if (full_ready)
               chk(cyc == n_exp + 2, "R9", "cycles to done", 64'(cyc), 64'(n_exp + 2));
         end
      end
      chk(seen_done, "R9", "done seen", {63'h0, seen_done}, 64'd1);
      @(negedge clk);
      req_ready = 1'b0;
      chk(!done && !busy, "R9", "done single pulse", {62'h0, done, busy}, 64'd0);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R11 reset state
      repeat (3) @(negedge clk);
      chk(!busy && !req_valid && !done, "R11", "in reset",
          {61'h0, busy, req_valid, done}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !req_valid && !done, "R11", "after reset",
          {61'h0, busy, req_valid, done}, 64'd0);

      // Table walk, each row with full and stalling ready (R8)
      for (int r = 0; r < NV; r++) begin
         run_case(VT[r], 1'b1, 1'b0);
         run_case(VT[r], 1'b0, 1'b0);
      end

      // R1: nothing requested gives no store requests
      build_expected(VT[6]);
      chk(n_exp == 0, "R1", "empty requested set", 64'(n_exp), 64'd0);
      run_case(VT[6], 1'b1, 1'b0);

      // R5: control/status word with in-use cleared
      build_expected(VT[3]);
      chk(n_exp == 1 && ek[0] == 3'd2, "R5", "csr only plan", 64'(n_exp), 64'd1);

      // R10: restart during a long sequence
      run_case(VT[0], 1'b0, 1'b1);
      run_case(VT[2], 1'b1, 1'b1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule